// File: doc/BRIEF.md
# Queued DMA Command Engine

This block accepts DMA commands from a small register file, holds them in a ten-entry first-in first-out command queue, and carries out one command at a time as a series of bursts. Software first programs a source address, a destination address and two lengths counted in 32-bit words. The final write, to the destination-length register, commits all four values as one queued command. Addresses are rounded down to a word boundary and lengths are turned into byte counts when the command is captured.

The engine works on the command at the head of the queue. Each burst is offered on a valid/ready port that carries a source address, a destination address, a byte count and a write flag. A memory agent moves the bytes. With loopback mode on, the agent reads the source and writes the same bytes to the destination. With loopback off, it only reads the source and streams those bytes out.

Finished commands and dropped pushes are recorded in a status register whose bits are cleared by writing ones. A mask register gates these bits onto a single level-sensitive interrupt line.

Top module: `dma_cmd_queue`

## Requirements
- R1: Register offsets are: 0x00 mode, 0x04 interrupt status, 0x08 interrupt mask, 0x0C queue status, 0x10 source address, 0x14 destination address, 0x18 source length, 0x1C destination length. Only bit 4 of the mode register (loopback) can be written. Only the low 27 bits of each length register can be written, and the upper bits read as zero.
- R2: A write to offset 0x1C queues one command built from the current source address, the current destination address, the current source length and the value being written. The two low bits of both addresses are cleared, and both lengths are multiplied by 4.
- R3: The queue holds 10 commands, counting the one in progress, and serves them first in, first out. A push while 10 are held is dropped and sets interrupt-status bit 14.
- R4: Every burst length equals the smallest of 1024, the remaining source bytes and, in loopback mode only, the remaining destination bytes.
- R5: An accepted burst advances the source address by its length and reduces the remaining source bytes by the same amount. In loopback mode the destination address and remaining destination bytes are updated the same way. Otherwise they stay unchanged. The burst write flag equals the loopback bit.
- R6: A command retires as soon as no more bytes can move: either the remaining source bytes are zero, or loopback is on and the remaining destination bytes are zero. On retirement it sets interrupt-status bits 13 (done) and 12 (partial done), and the next command takes its place. A zero-length command therefore retires without issuing any burst.
- R7: Writing a one to interrupt-status bits 31:27, 23:20 or 18:0 clears that bit, and writing a zero leaves it unchanged. Bits 26:24 and 19 are reserved and are never set. The mask register resets to 0xFFFFFFFF.
- R8: `irq` is high exactly when some status bit is set while its mask bit is clear. It follows every status write, every mask write and every retirement.
- R9: Queue status bit 31 is high when 10 commands are held, and bit 30 is high when none are held. After reset the queue status reads 0x40000000.
- R10: While `bst_valid` is high and `bst_ready` is low, and no register is written, the burst request holds valid with all its fields unchanged.
- R11: After reset the interrupt status is zero, `irq` is low and no burst is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte offset of the register write |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Byte offset of the register read |
| rd_data | output | 32 | Read data for the register at rd_addr, combinational |
| bst_valid | output | 1 | Burst request pending |
| bst_ready | input | 1 | Memory agent accepts the burst |
| bst_src | output | AW | Burst source byte address |
| bst_dst | output | AW | Burst destination byte address |
| bst_len | output | clog2(MAX_BURST+1) | Burst byte count |
| bst_wr | output | 1 | 1: write the bytes to bst_dst (loopback); 0: stream them out |
| irq | output | 1 | Interrupt, level |

## Verification
The bench drives unaligned addresses and odd word counts. A design that forgets to round the addresses or scale the lengths sends bursts that disagree with the reference queue model. Commands longer than 1024 bytes, and loopback commands whose destination is shorter than their source, test the burst cap. A missing cap produces an oversized burst. A cap on the wrong length either leaves the command unretired or retires it early.

A zero-length command must still report done, and a design that waits for a burst here never sets bits 13 and 12. An eleventh push while the agent stalls must be dropped with bit 14 set. A design that accepts it emits a burst nobody expects.

Masking and write-one-to-clear are exercised bit by bit. This exposes an interrupt that ignores the mask and a clear that wipes neighbouring bits.

// File: rtl/dma_cmd_queue.sv
module dma_cmd_queue #(
  parameter int DEPTH     = 10,
  parameter int MAX_BURST = 1024,
  parameter int LEN_BITS  = 27,
  parameter int AW        = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [4:0]                     wr_addr,
  input  logic [31:0]                    wr_data,
  input  logic [4:0]                     rd_addr,
  output logic [31:0]                    rd_data,
  output logic                           bst_valid,
  input  logic                           bst_ready,
  output logic [AW-1:0]                  bst_src,
  output logic [AW-1:0]                  bst_dst,
  output logic [$clog2(MAX_BURST+1)-1:0] bst_len,
  output logic                           bst_wr,
  output logic                           irq
);
  localparam int PW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int BLW = LEN_BITS + 2;
  localparam int BW  = $clog2(MAX_BURST + 1);
  localparam logic [4:0] A_MODE = 5'h00, A_STS = 5'h04, A_MASK = 5'h08, A_QST = 5'h0C;
  localparam logic [4:0] A_SRC = 5'h10, A_DST = 5'h14, A_SLEN = 5'h18, A_DLEN = 5'h1C;
  localparam logic [31:0] RSVD = 32'h0708_0000;

  logic                loop_q;
  logic [31:0]         sts_q, mask_q;
  logic [AW-1:0]       src_r, dst_r;
  logic [LEN_BITS-1:0] slen_r, dlen_r;
  logic [PW-1:0]       head, tail;
  logic [CW-1:0]       cnt;
  logic [AW-1:0]       q_src [DEPTH];
  logic [AW-1:0]       q_dst [DEPTH];
  logic [BLW-1:0]      q_sl  [DEPTH];
  logic [BLW-1:0]      q_dl  [DEPTH];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic full, empty, push, push_ok, drop, retire, fire;
  logic [BLW-1:0] c_src, cap;
  logic [31:0] w1c, set_bits;

  assign full    = cnt == CW'(DEPTH);
  assign empty   = cnt == '0;
  assign push    = wr_en && wr_addr == A_DLEN;
  assign push_ok = push && !full;
  assign drop    = push && full;
  assign c_src   = (q_sl[head] < BLW'(MAX_BURST)) ? q_sl[head] : BLW'(MAX_BURST);
  assign cap     = (loop_q && q_dl[head] < c_src) ? q_dl[head] : c_src;
  assign retire  = !empty && cap == '0;
  assign bst_valid = !empty && cap != '0;
  assign fire    = bst_valid && bst_ready;
  assign bst_src = q_src[head];
  assign bst_dst = q_dst[head];
  assign bst_len = cap[BW-1:0];
  assign bst_wr  = loop_q;
  assign w1c      = (wr_en && wr_addr == A_STS) ? (wr_data & ~RSVD) : '0;
  assign set_bits = {17'b0, drop, retire, retire, 12'b0};
  assign irq      = |(sts_q & ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q <= 1'b0;
      sts_q  <= '0;
      mask_q <= '1;
      src_r  <= '0;
      dst_r  <= '0;
      slen_r <= '0;
      dlen_r <= '0;
      head   <= '0;
      tail   <= '0;
      cnt    <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_MODE:  loop_q <= wr_data[4];
          A_MASK:  mask_q <= wr_data;
          A_SRC:   src_r  <= wr_data[AW-1:0];
          A_DST:   dst_r  <= wr_data[AW-1:0];
          A_SLEN:  slen_r <= wr_data[LEN_BITS-1:0];
          A_DLEN:  dlen_r <= wr_data[LEN_BITS-1:0];
          default: ;
        endcase
      end
      sts_q <= (sts_q & ~w1c) | set_bits;
      if (push_ok) tail <= nxt(tail);
      if (retire)  head <= nxt(head);
      cnt <= cnt + CW'(push_ok) - CW'(retire);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      q_src[tail] <= src_r & ~AW'(3);
      q_dst[tail] <= dst_r & ~AW'(3);
      q_sl[tail]  <= {slen_r, 2'b00};
      q_dl[tail]  <= {wr_data[LEN_BITS-1:0], 2'b00};
    end
    if (fire) begin
      q_src[head] <= q_src[head] + AW'(bst_len);
      q_sl[head]  <= q_sl[head] - BLW'(bst_len);
      if (loop_q) begin
        q_dst[head] <= q_dst[head] + AW'(bst_len);
        q_dl[head]  <= q_dl[head] - BLW'(bst_len);
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_MODE:  rd_data = {27'b0, loop_q, 4'b0};
      A_STS:   rd_data = sts_q;
      A_MASK:  rd_data = mask_q;
      A_QST:   rd_data = {full, empty, 30'b0};
      A_SRC:   rd_data = 32'(src_r);
      A_DST:   rd_data = 32'(dst_r);
      A_SLEN:  rd_data = 32'(slen_r);
      A_DLEN:  rd_data = 32'(dlen_r);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dma_cmd_queue_chk.sv
module dma_cmd_queue_chk #(
  parameter int DEPTH     = 10,
  parameter int MAX_BURST = 1024,
  parameter int AW        = 32,
  parameter int CW        = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_en,
  input logic [4:0]                     wr_addr,
  input logic                           bst_valid,
  input logic                           bst_ready,
  input logic [AW-1:0]                  bst_src,
  input logic [AW-1:0]                  bst_dst,
  input logic [$clog2(MAX_BURST+1)-1:0] bst_len,
  input logic                           bst_wr,
  input logic [CW-1:0]                  cnt,
  input logic [31:0]                    sts_q,
  input logic                           loop_q
);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid && !bst_ready && !wr_en |=> bst_valid && $stable(bst_src) &&
    $stable(bst_dst) && $stable(bst_len) && $stable(bst_wr));

  a_r4_len_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> bst_len != '0 && 32'(bst_len) <= MAX_BURST && bst_len[1:0] == 2'b00);

  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> bst_src[1:0] == 2'b00 && bst_dst[1:0] == 2'b00);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= DEPTH);

  a_r3_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 5'h1C && 32'(cnt) == DEPTH |=> sts_q[14]);

  a_r5_stream_mode: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid && !loop_q |-> !bst_wr);

  a_r7_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[26:24] == 3'b000 && !sts_q[19]);
endmodule

bind dma_cmd_queue dma_cmd_queue_chk #(
  .DEPTH(DEPTH), .MAX_BURST(MAX_BURST), .AW(AW), .CW($clog2(DEPTH + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .bst_valid(bst_valid), .bst_ready(bst_ready), .bst_src(bst_src),
  .bst_dst(bst_dst), .bst_len(bst_len), .bst_wr(bst_wr),
  .cnt(cnt), .sts_q(sts_q), .loop_q(loop_q)
);

// File: tb/dma_cmd_queue_test.sv
module dma_cmd_queue_test;
  localparam int MAXB = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        wr_en = 1'b0, bst_ready = 1'b0;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  wire  [31:0] rd_data, bst_src, bst_dst;
  wire  [10:0] bst_len;
  wire         bst_valid, bst_wr, irq;

  dma_cmd_queue uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .bst_valid(bst_valid), .bst_ready(bst_ready),
    .bst_src(bst_src), .bst_dst(bst_dst), .bst_len(bst_len), .bst_wr(bst_wr), .irq(irq)
  );

  int checks = 0, errors = 0;
  logic [31:0] m_src [0:255];
  logic [31:0] m_dst [0:255];
  int m_sl [0:255];
  int m_dl [0:255];
  int m_h = 0, m_t = 0;
  bit m_loop = 1'b0, agent_en = 1'b1;

  function automatic int mcap(int i);
    int c;
    c = (m_sl[i] < MAXB) ? m_sl[i] : MAXB;
    if (m_loop && m_dl[i] < c) c = m_dl[i];
    return c;
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int c;
    if (!rst_n || !bst_valid || !agent_en || ($urandom % 4) == 0) bst_ready = 1'b0;
    else begin
      bst_ready = 1'b1;
      while (m_h < m_t && mcap(m_h) == 0) m_h++;
      if (m_h >= m_t) chk(1'b0, "R3 burst with no queued command", {bst_src, bst_len}, 0);
      else begin
        c = mcap(m_h);
        chk({bst_src, bst_dst, bst_len, bst_wr} == {m_src[m_h], m_dst[m_h], c[10:0], m_loop},
            "R4 R5 burst fields", {bst_src, bst_dst, bst_len, bst_wr},
            {m_src[m_h], m_dst[m_h], c[10:0], m_loop});
        m_src[m_h] += c;
        m_sl[m_h]  -= c;
        if (m_loop) begin
          m_dst[m_h] += c;
          m_dl[m_h]  -= c;
        end
      end
    end
  end

  task automatic wreg(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rreg(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic push(logic [31:0] s, logic [31:0] d, logic [31:0] sl, logic [31:0] dl, bit drop);
    wreg(5'h10, s);
    wreg(5'h14, d);
    wreg(5'h18, sl);
    if (!drop) begin
      m_src[m_t] = s & ~32'd3;
      m_dst[m_t] = d & ~32'd3;
      m_sl[m_t]  = int'(sl & 32'h07FF_FFFF) * 4;
      m_dl[m_t]  = int'(dl & 32'h07FF_FFFF) * 4;
      m_t++;
    end
    wreg(5'h1C, dl);
  endtask

  task automatic wait_idle(string req);
    logic [31:0] q;
    do rreg(5'h0C, q); while (!q[30]);
    while (m_h < m_t && mcap(m_h) == 0) m_h++;
    chk(m_h == m_t, req, 128'(m_t - m_h), 0);
  endtask

  task automatic set_mode(bit lb);
    m_loop = lb;
    wreg(5'h00, {27'b0, lb, 4'b0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rreg(5'h08, v); chk(v == 32'hFFFF_FFFF, "R7 mask reset", v, 32'hFFFF_FFFF);
    rreg(5'h0C, v); chk(v == 32'h4000_0000, "R9 queue status reset", v, 32'h4000_0000);
    rreg(5'h04, v); chk(v == 0, "R11 status reset", v, 0);
    chk(!irq && !bst_valid, "R11 outputs idle", {irq, bst_valid}, 0);

    wreg(5'h18, 32'hFFFF_FFFF); rreg(5'h18, v);
    chk(v == 32'h07FF_FFFF, "R1 length width", v, 32'h07FF_FFFF);
    wreg(5'h00, 32'hFFFF_FFFF); rreg(5'h00, v);
    chk(v == 32'h0000_0010, "R1 mode width", v, 32'h10);

    set_mode(1'b1);
    push(32'h0000_1003, 32'h0000_2002, 300, 300, 1'b0);
    wait_idle("R2 R6 loopback long command");
    rreg(5'h04, v); chk(v == 32'h0000_3000, "R6 done bits", v, 32'h3000);
    chk(!irq, "R8 all masked", irq, 0);
    wreg(5'h08, ~32'h0000_2000);
    chk(irq, "R8 unmasked done", irq, 1);
    wreg(5'h04, 32'h0000_2000);
    rreg(5'h04, v); chk(v == 32'h0000_1000, "R7 clear one bit", v, 32'h1000);
    chk(!irq, "R8 after clear", irq, 0);
    wreg(5'h04, 32'hFFFF_FFFF);
    rreg(5'h04, v); chk(v == 0, "R7 clear all", v, 0);
    wreg(5'h08, 32'hFFFF_FFFF);

    push(32'h0000_4000, 32'h0000_8001, 10, 4, 1'b0);
    wait_idle("R4 loopback short destination");

    set_mode(1'b0);
    wreg(5'h04, 32'hFFFF_FFFF);
    push(32'h0001_0000, 32'h0002_0000, 0, 0, 1'b0);
    wait_idle("R6 zero length");
    rreg(5'h04, v); chk(v == 32'h0000_3000, "R6 zero length done", v, 32'h3000);

    push(32'h0003_0006, 32'h0009_0000, 600, 0, 1'b0);
    wait_idle("R5 stream command");

    wreg(5'h04, 32'hFFFF_FFFF);
    agent_en = 1'b0;
    for (int i = 0; i < 10; i++) push(32'h0010_0000 + 32'(i) * 64, 32'h0, 8, 0, 1'b0);
    rreg(5'h0C, v); chk(v == 32'h8000_0000, "R9 queue full", v, 32'h8000_0000);
    rreg(5'h04, v); chk(v[14] == 1'b0, "R3 no overflow yet", v, 0);
    push(32'h00FF_0000, 32'h0, 8, 0, 1'b1);
    rreg(5'h04, v); chk(v == 32'h0000_4000, "R3 overflow flag", v, 32'h4000);
    agent_en = 1'b1;
    wait_idle("R3 ten commands drained in order");

    for (int b = 0; b < 4; b++) begin
      set_mode(b[0]);
      for (int i = 0; i < 12; i++) begin
        do rreg(5'h0C, v); while (v[31]);
        push($urandom, $urandom, $urandom_range(0, 700), $urandom_range(0, 700), 1'b0);
      end
      wait_idle("R4 random batch");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule